// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Unit

This block gives software control over 32 bidirectional pins and a second bank of 32 output-only ports through a 16-bit register bus. Each bidirectional pin has its own direction, output value, trigger type (edge or level), sense (high/rising or low/falling), hold-or-pass-through status behaviour and interrupt enable. Every input passes through a two-stage synchronizer before detection. Detected events land in a per-pin status word, which is also driven out raw. Enabled status bits are ORed into one registered interrupt line. Two 16-bit pull registers are held and driven out as plain settings.

Every configuration word is 32 bits wide and takes two halfword accesses. Halfword addresses: 0/1 direction, 2/3 low-bank data, 4/5 status, 6/7 interrupt enable, 8/9 trigger type, 10/11 sense, 12/13 hold select, 14/15 high-bank output data, 16 pull enable, 17 pull select. Unused addresses read 0. A read returns its halfword on `bus_rdata` in the cycle after the access.

Top module: `gpio_irq_unit`

## Requirements
- R1: A 32-bit register is reached at an even halfword address for bits 15:0 and at the next address for bits 31:16. Read data appears on `bus_rdata` one clock after the read access and holds until the next read.
- R2: After reset, direction, interrupt enable, sense, hold select, both data banks, status and both pull registers are 0, trigger type is all ones (edge), and `irq` and `pin_oe` are 0.
- R3: A direction bit of 1 makes the pin an output: `pin_oe` follows the direction word and `pin_out` the low-bank data word. A low-bank data read returns the written value for output pins and the synchronized pin level for input pins.
- R4: Port 32+k is bit k of the high-bank word (addresses 14/15), driven on `port_hi_out` and read back as written. It has no input or interrupt path.
- R5: With trigger bit 0 (level), sense 1 means active high and sense 0 means active low. With hold bit 0, the status bit follows the live synchronized condition.
- R6: With trigger bit 1 (edge), sense 1 detects a rising change and sense 0 a falling change of the synchronized input. With hold bit 1, the opposite change sets nothing.
- R7: With hold bit 1, a detected event stays in status until cleared. A status write clears each bit written as 1 and leaves bits written as 0 unchanged, so reading the status and writing it back clears all pending bits.
- R8: When an event and a clear of the same held status bit fall in the same cycle, the bit stays set.
- R9: A pin whose direction bit is 1 never sets a new status bit, whatever its pin input does.
- R10: `irq` is the OR over pins of status AND enable, registered. It rises one clock after the status bit and is 0 whenever the enable word was 0 in the previous cycle.
- R11: The pull-enable register (address 16) drives `pull_en`, and the pull-select register (address 17, 1 = up, 0 = down) drives `pull_sel`. Each changes only on a write to its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Halfword address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Low-bank output values |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| port_hi_out | output | 32 | Output-only bank, ports 32..63 |
| pull_en | output | 16 | Pull enable settings |
| pull_sel | output | 16 | Pull direction settings |
| raw_status | output | 32 | Per-pin status word |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench presents a clear in the same cycle as a fresh rising edge on a held pin. A design that let the clear win would lose that interrupt, and the status read shows the bit gone. It writes a status mask with only some bits set, which catches a design that clears the whole word or stores the written value. It also checks that the opposite edge is ignored in hold mode, and that toggling an output pin raises nothing. The interrupt line is sampled in the cycle after the status appears and again one cycle later, which exposes a missing or extra pipeline stage. Mixed-direction data reads show whether the mux picks the pin level or the latch for each bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word slots, halfword address = 2*slot + upper
  localparam int unsigned SLOT_DIR   = 0;
  localparam int unsigned SLOT_DOUT  = 1;
  localparam int unsigned SLOT_STAT  = 2;
  localparam int unsigned SLOT_IEN   = 3;
  localparam int unsigned SLOT_TRIG  = 4;
  localparam int unsigned SLOT_POL   = 5;
  localparam int unsigned SLOT_HOLD  = 6;
  localparam int unsigned SLOT_HIOUT = 7;
  localparam int unsigned NUM_SLOTS  = 8;
  localparam int unsigned ADDR_PULL_EN  = 2 * NUM_SLOTS;
  localparam int unsigned ADDR_PULL_SEL = 2 * NUM_SLOTS + 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] sync_i,
  input  logic [NPIN-1:0] dir_i,
  input  logic [NPIN-1:0] trig_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] hold_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] status_o
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] evt;
  logic [NPIN-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else prev_q <= sync_i;
  end

  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_pin
      logic lvl_hit, edge_hit;
      always_comb begin
        lvl_hit  = pol_i[i] ? sync_i[i] : ~sync_i[i];
        edge_hit = pol_i[i] ? (sync_i[i] & ~prev_q[i]) : (~sync_i[i] & prev_q[i]);
        evt[i]   = ~dir_i[i] & (trig_i[i] ? edge_hit : lvl_hit);
      end

      always_ff @(posedge clk) begin
        if (rst) st_q[i] <= 1'b0;
        else if (hold_i[i]) st_q[i] <= evt[i] | (st_q[i] & ~clr_i[i]);
        else st_q[i] <= evt[i];
      end
    end
  endgenerate

  assign status_o = st_q;

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(st_q & hold_i & ~clr_i) & ~st_q) == '0));

  // R9
  out_no_event_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((st_q & ~$past(st_q) & $past(dir_i)) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [2*DW-1:0] sync_i,
  input  logic [2*DW-1:0] status_i,
  output logic [2*DW-1:0] dir_o,
  output logic [2*DW-1:0] dout_o,
  output logic [2*DW-1:0] ien_o,
  output logic [2*DW-1:0] trig_o,
  output logic [2*DW-1:0] pol_o,
  output logic [2*DW-1:0] hold_o,
  output logic [2*DW-1:0] hiout_o,
  output logic [DW-1:0]   pull_en_o,
  output logic [DW-1:0]   pull_sel_o,
  output logic [2*DW-1:0] clr_o
);
  localparam int unsigned NP  = 2 * DW;
  localparam int unsigned IDW = $clog2(NUM_SLOTS);

  logic [NP-1:0]  word_q [NUM_SLOTS];
  logic [DW-1:0]  pen_q, psel_q;
  logic           wr_en, rd_en, in_slots, upper;
  logic [IDW-1:0] slot;
  logic [NP-1:0]  rd_word;
  logic [DW-1:0]  rd_half;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign slot     = bus_addr[IDW:1];
  assign upper    = bus_addr[0];
  assign in_slots = (bus_addr < AW'(2 * NUM_SLOTS));

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      if (g == SLOT_STAT) begin : g_none
        assign word_q[g] = '0;
      end else begin : g_reg
        localparam logic [NP-1:0] RST_VAL = (g == SLOT_TRIG) ? {NP{1'b1}} : '0;
        always_ff @(posedge clk) begin
          if (rst) word_q[g] <= RST_VAL;
          else if (wr_en && in_slots && slot == IDW'(g)) begin
            if (upper) word_q[g][NP-1:DW] <= bus_wdata;
            else word_q[g][DW-1:0] <= bus_wdata;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pen_q  <= '0;
      psel_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == AW'(ADDR_PULL_EN)) pen_q <= bus_wdata;
      if (bus_addr == AW'(ADDR_PULL_SEL)) psel_q <= bus_wdata;
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr_en && in_slots && slot == IDW'(SLOT_STAT)) begin
      if (upper) clr_o[NP-1:DW] = bus_wdata;
      else clr_o[DW-1:0] = bus_wdata;
    end
  end

  always_comb begin
    rd_word = word_q[slot];
    if (slot == IDW'(SLOT_DOUT))
      rd_word = (word_q[SLOT_DIR] & word_q[SLOT_DOUT]) | (~word_q[SLOT_DIR] & sync_i);
    else if (slot == IDW'(SLOT_STAT))
      rd_word = status_i;
    if (in_slots) rd_half = upper ? rd_word[NP-1:DW] : rd_word[DW-1:0];
    else if (bus_addr == AW'(ADDR_PULL_EN)) rd_half = pen_q;
    else if (bus_addr == AW'(ADDR_PULL_SEL)) rd_half = psel_q;
    else rd_half = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_half;
  end

  assign dir_o      = word_q[SLOT_DIR];
  assign dout_o     = word_q[SLOT_DOUT];
  assign ien_o      = word_q[SLOT_IEN];
  assign trig_o     = word_q[SLOT_TRIG];
  assign pol_o      = word_q[SLOT_POL];
  assign hold_o     = word_q[SLOT_HOLD];
  assign hiout_o    = word_q[SLOT_HIOUT];
  assign pull_en_o  = pen_q;
  assign pull_sel_o = psel_q;

  // R11
  pull_en_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(wr_en) && $past(bus_addr) == AW'(ADDR_PULL_EN)))
      |-> $stable(pull_en_o));

  // R4
  hiout_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(wr_en) && $past(bus_addr[AW-1:1]) == (AW-1)'(SLOT_HIOUT)))
      |-> $stable(hiout_o));

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(bus_rdata));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned DW      = 16,
  parameter int unsigned AW      = 5,
  parameter int unsigned SYNC_ST = 2,
  localparam int unsigned NP     = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NP-1:0] pin_in,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_oe,
  output logic [NP-1:0] port_hi_out,
  output logic [DW-1:0] pull_en,
  output logic [DW-1:0] pull_sel,
  output logic [NP-1:0] raw_status,
  output logic          irq
);
  logic [NP-1:0] sync_w, dir_w, dout_w, ien_w, trig_w, pol_w, hold_w, clr_w, stat_w;
  logic          irq_q;

  gpio_sync #(.WIDTH(NP), .STAGES(SYNC_ST)) sync_i (
    .clk(clk), .rst(rst), .async_i(pin_in), .sync_o(sync_w));

  gpio_regfile #(.DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_i(sync_w), .status_i(stat_w), .dir_o(dir_w), .dout_o(dout_w),
    .ien_o(ien_w), .trig_o(trig_w), .pol_o(pol_w), .hold_o(hold_w),
    .hiout_o(port_hi_out), .pull_en_o(pull_en), .pull_sel_o(pull_sel),
    .clr_o(clr_w));

  gpio_detect #(.NPIN(NP)) det_i (
    .clk(clk), .rst(rst), .sync_i(sync_w), .dir_i(dir_w), .trig_i(trig_w),
    .pol_i(pol_w), .hold_i(hold_w), .clr_i(clr_w), .status_o(stat_w));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= |(stat_w & ien_w);
  end

  assign irq        = irq_q;
  assign pin_out    = dout_w;
  assign pin_oe     = dir_w;
  assign raw_status = stat_w;

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ien_w) == '0) |-> !irq);

  // R2
  irq_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && pin_oe == '0));
endmodule

// File: tb/gpio_irq_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, port_hi_out, raw_status;
  logic [15:0] pull_en, pull_sel;
  logic        irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_irq_unit dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .port_hi_out(port_hi_out), .pull_en(pull_en), .pull_sel(pull_sel),
    .raw_status(raw_status), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    wr16(a, d[15:0]);
    wr16(a + 5'd1, d[31:16]);
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd16(a, lo);
    rd16(a + 5'd1, hi);
    d = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R2 irq", {31'b0, irq}, 32'h0);
    chk("R2 pin_oe", pin_oe, 32'h0);
    chk("R2 pin_out", pin_out, 32'h0);
    chk("R2 port_hi_out", port_hi_out, 32'h0);
    chk("R2 pulls", {pull_en, pull_sel}, 32'h0);
    rd32(5'd0, v);  chk("R2 dir", v, 32'h0);
    rd32(5'd4, v);  chk("R2 status", v, 32'h0);
    rd32(5'd6, v);  chk("R2 ien", v, 32'h0);
    rd32(5'd8, v);  chk("R2 trig", v, 32'hFFFF_FFFF);
    rd32(5'd12, v); chk("R2 hold", v, 32'h0);
  endtask

  task automatic t_halfword;
    logic [15:0] h;
    logic [31:0] v;
    wr16(5'd6, 16'h5A5A);
    wr16(5'd7, 16'hA5A5);
    rd16(5'd6, h); chk("R1 low half", {16'h0, h}, 32'h5A5A);
    rd16(5'd7, h); chk("R1 high half", {16'h0, h}, 32'hA5A5);
    idle(2);
    chk("R1 rdata held", {16'h0, bus_rdata}, 32'hA5A5);
    rd32(5'd6, v); chk("R1 word", v, 32'hA5A5_5A5A);
    wr32(5'd6, 32'h0);
  endtask

  task automatic t_output;
    logic [31:0] v;
    wr32(5'd0, 32'h0000_FFFF);
    wr32(5'd2, 32'h1234_ABCD);
    pin_in = 32'hFFFF_0000;
    idle(4);
    chk("R3 pin_oe", pin_oe, 32'h0000_FFFF);
    chk("R3 pin_out", pin_out, 32'h1234_ABCD);
    rd32(5'd2, v); chk("R3 mixed data read", v, 32'hFFFF_ABCD);
    pin_in = 32'h0;
    wr32(5'd0, 32'h0);
    idle(4);
    rd32(5'd2, v); chk("R3 input data read", v, 32'h0);
  endtask

  task automatic t_hibank;
    logic [31:0] v;
    wr32(5'd14, 32'h8000_0001);
    chk("R4 port_hi_out", port_hi_out, 32'h8000_0001);
    chk("R4 low bank untouched", pin_out, 32'h1234_ABCD);
    rd32(5'd14, v); chk("R4 readback", v, 32'h8000_0001);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr32(5'd8, ~32'h30);
    wr32(5'd10, 32'h10);
    pin_in[4] = 1'b1; pin_in[5] = 1'b1;
    idle(5);
    rd32(5'd4, v); chk("R5 level high/low, pins high", v, 32'h10);
    pin_in[4] = 1'b0; pin_in[5] = 1'b0;
    idle(5);
    rd32(5'd4, v); chk("R5 level follows, pins low", v, 32'h20);
    wr32(5'd8, 32'hFFFF_FFFF);
    wr32(5'd10, 32'h0);
    idle(3);
    rd32(5'd4, v); chk("R5 back to edge idle", v, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr32(5'd12, 32'h300);
    wr32(5'd10, 32'h100);
    pin_in[8] = 1'b1; idle(5);
    rd32(5'd4, v); chk("R6 rising caught", v, 32'h100);
    pin_in[8] = 1'b0; idle(5);
    rd32(5'd4, v); chk("R7 held after pin falls", v, 32'h100);
    pin_in[9] = 1'b1; idle(5);
    rd32(5'd4, v); chk("R6 rising ignored on falling pin", v, 32'h100);
    pin_in[9] = 1'b0; idle(5);
    rd32(5'd4, v); chk("R6 falling caught", v, 32'h300);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr16(5'd4, 16'h0100);
    rd32(5'd4, v); chk("R7 partial clear", v, 32'h200);
    rd32(5'd4, v);
    wr32(5'd4, v);
    rd32(5'd4, v); chk("R7 readback writeback clears", v, 32'h0);
  endtask

  task automatic t_irq;
    wr32(5'd6, 32'h100);
    @(negedge clk); pin_in[8] = 1'b1;
    idle(3);
    chk("R10 status visible", raw_status, 32'h100);
    chk("R10 irq not yet", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R10 irq one cycle later", {31'b0, irq}, 32'h1);
    wr32(5'd6, 32'h0);
    idle(1);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    pin_in[8] = 1'b0;
    wr16(5'd4, 16'h0100);
    idle(3);
    chk("R7 cleared raw", raw_status, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr32(5'd12, 32'h700);
    wr32(5'd10, 32'h500);
    pin_in[10] = 1'b1; idle(5);
    pin_in[10] = 1'b0; idle(5);
    rd32(5'd4, v); chk("R8 preset", v, 32'h400);
    @(negedge clk); pin_in[10] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'd4; bus_wdata = 16'h0400;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd32(5'd4, v); chk("R8 event beats clear", v, 32'h400);
    pin_in[10] = 1'b0;
    wr16(5'd4, 16'h0400);
    rd32(5'd4, v); chk("R8 later clear works", v, 32'h0);
  endtask

  task automatic t_outpin;
    logic [31:0] v;
    wr32(5'd0, 32'h1000);
    wr32(5'd12, 32'h1000);
    wr32(5'd10, 32'h1000);
    pin_in[12] = 1'b1; idle(5);
    pin_in[12] = 1'b0; idle(5);
    rd32(5'd4, v); chk("R9 output pin raises nothing", v, 32'h0);
    wr32(5'd0, 32'h0);
  endtask

  task automatic t_pull;
    wr16(5'd16, 16'hC3C3);
    chk("R11 pull_en", {16'h0, pull_en}, 32'hC3C3);
    chk("R11 pull_sel untouched", {16'h0, pull_sel}, 32'h0);
    wr16(5'd17, 16'h0F0F);
    chk("R11 pull_sel", {16'h0, pull_sel}, 32'h0F0F);
    chk("R11 pull_en kept", {16'h0, pull_en}, 32'hC3C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_halfword();
    t_output();
    t_hibank();
    t_level();
    t_edge();
    t_w1c();
    t_irq();
    t_collide();
    t_outpin();
    t_pull();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule